// File: doc/BRIEF.md
# Staged Memory Unit

The block is a small byte-wide random-access store that sits on a shared 8-bit data bus and reaches that bus only through two staging registers. An address register captures the low bits of the bus. A separate write-data register captures the full bus byte. A write command then moves the staged byte into the staged location, so the bus value during the write cycle does not matter. A read command registers the addressed byte and presents it on the bus output with a drive enable one cycle later. A chip-level tri-state buffer is built from that data and enable pair. Outside a read, the output is quiet.

All four commands are active low and are sampled on the rising clock edge. A synchronous active-high reset clears the staging registers and the read port. It never clears the storage array, so contents loaded before a reset survive it. Bus arbitration and the control sequencer that issues the commands lie outside the block.

Top module: `staged_mem_unit`

## Requirements
- R1: When `rst` is high at a rising edge, the next cycle shows `stg_addr` = 0, `stg_data` = 0, `bus_oe` = 0 and `bus_out` = 0, and no write takes place.
- R2: When `ld_addr_n` is low at a rising edge, `stg_addr` takes `bus_in[ADDR_W-1:0]` and ignores the upper bus bits. When `ld_addr_n` is high, `stg_addr` holds its value.
- R3: When `ld_data_n` is low at a rising edge, `stg_data` takes all of `bus_in`. When `ld_data_n` is high, `stg_data` holds its value.
- R4: When `wr_n` is low at a rising edge, the location selected by `stg_addr` takes the value of `stg_data` from before that edge. The value on `bus_in` in that cycle has no effect on the stored byte.
- R5: When `rd_n` is low at a rising edge, the following cycle shows `bus_oe` = 1 and `bus_out` equal to the byte held, before that edge, at the `stg_addr` value from before that edge.
- R6: When `rd_n` is high at a rising edge, the following cycle shows `bus_oe` = 0 and `bus_out` = 0.
- R7: Reset leaves the storage array untouched. Bytes written before a reset read back unchanged after it.
- R8: When `wr_n` and `rd_n` are both low at the same edge, the write still happens. The read returns the byte held before the write, and a later read returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | DATA_W | Value currently present on the shared bus |
| ld_addr_n | input | 1 | Load address staging register, active low |
| ld_data_n | input | 1 | Load write-data staging register, active low |
| wr_n | input | 1 | Write staged byte to staged address, active low |
| rd_n | input | 1 | Read addressed byte onto the bus, active low |
| bus_out | output | DATA_W | Registered read byte, zero when not driving |
| bus_oe | output | 1 | Bus drive enable for the tri-state buffer |
| stg_addr | output | ADDR_W | Current staged address |
| stg_data | output | DATA_W | Current staged write byte |

## Verification
The bench builds the unit with its default 4-bit address and 8-bit data widths. These widths give a 16-entry array that is small enough to fill and read back completely. Every location is written with a distinct pattern while the bus carries the inverse pattern, and then each location is read back. This exposes address decode faults, aliasing between locations and any leak of the bus value into the write path. Reset in the middle of a read, a combined write and read, and an address load during a read cover the ordering cases.

// File: rtl/smu_pkg.sv
package smu_pkg;

    localparam int SMU_ADDR_W = 4;
    localparam int SMU_DATA_W = 8;

    // Decoded, active-high command set for one cycle
    typedef struct packed {
        logic load_addr;
        logic load_data;
        logic write;
        logic read;
    } smu_ctl_t;

    function automatic int smu_depth(input int addr_w);
        return 1 << addr_w;
    endfunction

    // Reset suppresses every command; inputs are active low
    function automatic smu_ctl_t smu_decode(
        input logic rst,
        input logic ld_addr_n,
        input logic ld_data_n,
        input logic wr_n,
        input logic rd_n
    );
        smu_ctl_t c;
        c.load_addr = !rst && !ld_addr_n;
        c.load_data = !rst && !ld_data_n;
        c.write     = !rst && !wr_n;
        c.read      = !rst && !rd_n;
        return c;
    endfunction

endpackage

// File: rtl/smu_stage_regs.sv
module smu_stage_regs #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_addr,
    input  logic              load_data,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (load_addr) addr_q <= bus_in[ADDR_W-1:0];
            if (load_data) data_q <= bus_in;
        end
    end

    AST_STAGE_CLEAR: assert property (@(posedge clk)
        rst |=> (addr_q == '0) && (data_q == '0)); // R1
    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_addr |=> addr_q == $past(bus_in[ADDR_W-1:0])); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_addr |=> $stable(addr_q)); // R2
    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_data |=> data_q == $past(bus_in)); // R3
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_data |=> $stable(data_q)); // R3

endmodule

// File: rtl/smu_array.sv
module smu_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_q,
    output logic              rd_valid
);

    localparam int DEPTH = smu_pkg::smu_depth(ADDR_W);

    logic [DATA_W-1:0] cells [DEPTH];

    // One row per location; no reset so contents survive rst
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (we && (addr == ADDR_W'(g))) cells[g] <= wdata;
        end
    end

    // Registered read port samples the pre-write contents
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q     <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= re;
            rd_q     <= re ? cells[addr] : '0;
        end
    end

    AST_RD_AFTER_RESET: assert property (@(posedge clk)
        rst |=> !rd_valid); // R1
    AST_RD_ENABLE: assert property (@(posedge clk) disable iff (rst)
        re |=> rd_valid); // R5
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !re |=> !rd_valid && (rd_q == '0)); // R6

endmodule

// File: rtl/smu_bus_drv.sv
module smu_bus_drv #(
    parameter int DATA_W = 8
) (
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);

    // Zero when idle so a wired-OR or tri-state stage sees no stray bits
    always_comb begin
        bus_oe  = valid;
        bus_out = valid ? data : '0;
    end

endmodule

// File: rtl/staged_mem_unit.sv
module staged_mem_unit #(
    parameter int ADDR_W = smu_pkg::SMU_ADDR_W,
    parameter int DATA_W = smu_pkg::SMU_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              ld_addr_n,
    input  logic              ld_data_n,
    input  logic              wr_n,
    input  logic              rd_n,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] stg_addr,
    output logic [DATA_W-1:0] stg_data
);

    smu_pkg::smu_ctl_t ctl;
    logic [DATA_W-1:0] rd_q;
    logic              rd_valid;

    assign ctl = smu_pkg::smu_decode(rst, ld_addr_n, ld_data_n, wr_n, rd_n);

    smu_stage_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .load_addr (ctl.load_addr),
        .load_data (ctl.load_data),
        .bus_in    (bus_in),
        .addr_q    (stg_addr),
        .data_q    (stg_data)
    );

    smu_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .we       (ctl.write),
        .re       (ctl.read),
        .addr     (stg_addr),
        .wdata    (stg_data),
        .rd_q     (rd_q),
        .rd_valid (rd_valid)
    );

    smu_bus_drv #(.DATA_W(DATA_W)) u_drv (
        .valid   (rd_valid),
        .data    (rd_q),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    AST_OE_TRACKS_RD: assert property (@(posedge clk) disable iff (rst)
        !rd_n |=> bus_oe); // R5
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        rd_n |=> !bus_oe && (bus_out == '0)); // R6

endmodule

// File: tb/sim_staged_mem_unit.sv
module sim_staged_mem_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_in;
    logic       ld_addr_n, ld_data_n, wr_n, rd_n;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [3:0] stg_addr;
    logic [7:0] stg_data;

    always #5 clk = ~clk;

    staged_mem_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_in    (bus_in),
        .ld_addr_n (ld_addr_n),
        .ld_data_n (ld_data_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .stg_addr  (stg_addr),
        .stg_data  (stg_data)
    );

    typedef struct packed {
        logic       oe;
        logic [7:0] dout;
        logic [3:0] a;
        logic [7:0] d;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    checks = 0;
    int    fails  = 0;
    bit    finished = 0;

    logic [7:0] mdl_mem [16];
    logic [3:0] mdl_a;
    logic [7:0] mdl_d;

    function automatic logic [7:0] pat(input int i);
        return 8'h5A ^ 8'(i * 37);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outcome
    task automatic step(input bit r, input bit la, input bit ld, input bit w,
                        input bit rd, input logic [7:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        rst       = r;
        ld_addr_n = !la;
        ld_data_n = !ld;
        wr_n      = !w;
        rd_n      = !rd;
        bus_in    = b;
        if (r) begin
            e.oe = 1'b0; e.dout = 8'h00;
            mdl_a = 4'h0; mdl_d = 8'h00;
        end else begin
            e.oe   = rd;
            e.dout = rd ? mdl_mem[mdl_a] : 8'h00;
            if (w)  mdl_mem[mdl_a] = mdl_d;
            if (la) mdl_a = b[3:0];
            if (ld) mdl_d = b;
        end
        e.a = mdl_a;
        e.d = mdl_d;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    // Monitor: compares one queued item per cycle after the edge settles
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (expq.size() > 0) begin
                e = expq.pop_front();
                t = tagq.pop_front();
                chk(t, "bus_oe",   int'(bus_oe),   int'(e.oe));
                chk(t, "bus_out",  int'(bus_out),  int'(e.dout));
                chk(t, "stg_addr", int'(stg_addr), int'(e.a));
                chk(t, "stg_data", int'(stg_data), int'(e.d));
            end
        end
    end

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; ld_addr_n = 1'b1; ld_data_n = 1'b1;
        wr_n = 1'b1; rd_n = 1'b1; bus_in = 8'h00;
        mdl_a = 4'h0; mdl_d = 8'h00;

        // R1 reset state
        step(1, 0, 0, 0, 0, 8'h00, "R1");
        step(1, 0, 0, 0, 0, 8'hFF, "R1");

        // R2 address load uses only the low nibble, then holds
        step(0, 1, 0, 0, 0, 8'hA5, "R2");
        step(0, 0, 0, 0, 0, 8'h3B, "R2");
        // R3 data load and hold
        step(0, 0, 1, 0, 0, 8'hC3, "R3");
        step(0, 0, 0, 0, 0, 8'h11, "R3");

        // R4 fill all locations; bus carries the inverse pattern during the write
        for (int i = 0; i < 16; i++) begin
            step(0, 1, 0, 0, 0, {4'(15 - i), 4'(i)}, "R4");
            step(0, 0, 1, 0, 0, pat(i), "R4");
            step(0, 0, 0, 1, 0, ~pat(i), "R4");
        end

        // R5 read back every location
        for (int i = 0; i < 16; i++) begin
            step(0, 1, 0, 0, 0, {~4'(i), 4'(i)}, "R5");
            step(0, 0, 0, 0, 1, 8'h00, "R5");
        end
        // R6 idle after reads
        step(0, 0, 0, 0, 0, 8'hEE, "R6");
        step(0, 0, 0, 0, 0, 8'h00, "R6");

        // R1 reset right after a read clears the drive
        step(0, 1, 0, 0, 0, 8'h07, "R7");
        step(0, 0, 0, 0, 1, 8'h00, "R7");
        step(1, 0, 0, 0, 0, 8'h00, "R1");
        // R7 contents survive reset
        for (int i = 0; i < 4; i++) begin
            step(0, 1, 0, 0, 0, 8'(i * 5), "R7");
            step(0, 0, 0, 0, 1, 8'h00, "R7");
        end

        // R8 same-cycle write and read
        step(0, 1, 1, 0, 0, 8'h09, "R8");
        step(0, 0, 1, 0, 0, 8'h77, "R8");
        step(0, 0, 0, 1, 1, 8'h00, "R8");
        step(0, 0, 0, 0, 1, 8'h00, "R8");
        // R5 address load during a read uses the old address
        step(0, 1, 0, 0, 1, 8'h02, "R5");
        step(0, 0, 0, 0, 1, 8'h00, "R5");
        step(0, 0, 0, 0, 0, 8'h00, "R6");

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule